// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a 16-bit logical offset to a 24-bit physical address by base-and-bound segmentation with a privilege check. It keeps four segment registers: code, data, stack and extra. Each one holds a visible selector, which is an index into a descriptor table and not an address. Beside the selector sits a hidden cached descriptor made of a base, a limit and a privilege level. Because every translation reads only these cached copies, no translation touches memory.

A load port writes a selector into one register together with the descriptor already fetched for it, and this fills that register's cache. A request gives an offset, an access type and an optional segment override. One cycle later the block returns either the physical address or a fault code. The current privilege level (CPL) is always the privilege level held in the code register's cached descriptor.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, every selector reads 0. Every cached descriptor holds base 0, limit 16'hFFFF and privilege level 0, so the CPL is 0. `rsp_valid_o` is low.
- R2: A load with `ld_valid_i` high writes the selector and descriptor into the register named by `ld_seg_i`: 0 code, 1 data, 2 stack, 3 extra. `vis_sel_o` shows the stored selector of the register named by `vis_seg_i`, combinationally.
- R3: `rsp_valid_o` is high in the cycle after a cycle with `req_valid_i` high, and low otherwise. The address of a fault-free response is (base + offset) mod 2^24.
- R4: An offset greater than the selected limit gives fault 2'b01. An offset equal to the limit is legal.
- R5: When the CPL is numerically greater than the selected segment's privilege level, the response carries fault 2'b10. The CPL is the privilege level in the code register's cached descriptor.
- R6: When both the limit check and the privilege check fail, the fault is 2'b01.
- R7: Without an override, `req_type_i` picks the segment: 2'b00 fetch uses code, 2'b10 stack uses stack, and 2'b01 or 2'b11 (both data) use data.
- R8: When `req_ovr_en_i` is high and the access is a data type (2'b01 or 2'b11), `req_ovr_seg_i` picks the register, with the same encoding as R2. For fetch and stack accesses the override is ignored.
- R9: A load in the same cycle as a request to the same register is forwarded, so that request already uses the new descriptor. A code register load in that cycle also sets the CPL used by that request.
- R10: A faulted response drives address 0. Fault code 2'b11 never appears. When `rsp_valid_o` is low, both address and fault are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Load a segment register this cycle |
| ld_seg_i | input | 2 | Register to load |
| ld_sel_i | input | 16 | Selector value |
| ld_base_i | input | 24 | Descriptor base |
| ld_limit_i | input | 16 | Descriptor limit (highest legal offset) |
| ld_dpl_i | input | 2 | Descriptor privilege level |
| req_valid_i | input | 1 | Translation request |
| req_type_i | input | 2 | Access type |
| req_ovr_en_i | input | 1 | Segment override enable |
| req_ovr_seg_i | input | 2 | Override register |
| req_off_i | input | 16 | Logical offset |
| vis_seg_i | input | 2 | Register whose selector is shown |
| vis_sel_o | output | 16 | Stored selector of that register |
| rsp_valid_o | output | 1 | Response valid |
| rsp_addr_o | output | 24 | Physical address |
| rsp_fault_o | output | 2 | 00 none, 01 limit, 10 privilege |

## Verification
A descriptor load and a translation request can fall in the same cycle and target the same register. The bench provokes this in three ways: a stack load with a stack request that also wraps past 2^24, a code load with a fetch, and a code load that lowers the CPL together with a data-override access that is only legal at the new level. Each of these responses is judged against the newly loaded descriptor rather than the old one, one cycle after issue. A privilege fault or a success shows which CPL was applied.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int NUM_SEG = 4;
  localparam int SEG_W   = 2;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH    = 2'd0,
    ACC_DATA     = 2'd1,
    ACC_STACK    = 2'd2,
    ACC_DATA_ALT = 2'd3
  } acc_type_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_PRIV  = 2'd2
  } fault_e;
endpackage

// File: rtl/seg_reg_bank.sv
module seg_reg_bank #(
  parameter int NUM_SEG  = 4,
  parameter int SEL_W    = 16,
  parameter int BASE_W   = 24,
  parameter int LIM_W    = 16,
  parameter int PL_W     = 2,
  parameter int CODE_IDX = 0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ld_valid_i,
  input  logic [$clog2(NUM_SEG)-1:0] ld_seg_i,
  input  logic [SEL_W-1:0]           ld_sel_i,
  input  logic [BASE_W-1:0]          ld_base_i,
  input  logic [LIM_W-1:0]           ld_limit_i,
  input  logic [PL_W-1:0]            ld_dpl_i,
  input  logic [$clog2(NUM_SEG)-1:0] rd_seg_i,
  output logic [BASE_W-1:0]          rd_base_o,
  output logic [LIM_W-1:0]           rd_limit_o,
  output logic [PL_W-1:0]            rd_dpl_o,
  output logic [PL_W-1:0]            cpl_o,
  input  logic [$clog2(NUM_SEG)-1:0] vis_seg_i,
  output logic [SEL_W-1:0]           vis_sel_o
);
  localparam int SEG_W = $clog2(NUM_SEG);

  logic [SEL_W-1:0]  sel_q   [NUM_SEG];
  logic [BASE_W-1:0] base_q  [NUM_SEG];
  logic [LIM_W-1:0]  limit_q [NUM_SEG];
  logic [PL_W-1:0]   dpl_q   [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic wr_en;
    assign wr_en = ld_valid_i && (ld_seg_i == SEG_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q[g]   <= '0;
        base_q[g]  <= '0;
        limit_q[g] <= '1;
        dpl_q[g]   <= '0;
      end else if (wr_en) begin
        sel_q[g]   <= ld_sel_i;
        base_q[g]  <= ld_base_i;
        limit_q[g] <= ld_limit_i;
        dpl_q[g]   <= ld_dpl_i;
      end
    end
  end

  // same-cycle load bypasses the cache
  logic hit_rd, hit_code;
  assign hit_rd   = ld_valid_i && (ld_seg_i == rd_seg_i);
  assign hit_code = ld_valid_i && (ld_seg_i == SEG_W'(CODE_IDX));

  assign rd_base_o  = hit_rd   ? ld_base_i  : base_q[rd_seg_i];
  assign rd_limit_o = hit_rd   ? ld_limit_i : limit_q[rd_seg_i];
  assign rd_dpl_o   = hit_rd   ? ld_dpl_i   : dpl_q[rd_seg_i];
  assign cpl_o      = hit_code ? ld_dpl_i   : dpl_q[CODE_IDX];
  assign vis_sel_o  = sel_q[vis_seg_i];
endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_xlate_pkg::*;
(
  input  logic [1:0]       acc_type_i,
  input  logic             ovr_en_i,
  input  logic [SEG_W-1:0] ovr_seg_i,
  output logic [SEG_W-1:0] seg_o
);
  always_comb begin
    unique case (acc_type_e'(acc_type_i))
      ACC_FETCH: seg_o = SEG_CODE;
      ACC_STACK: seg_o = SEG_STACK;
      default:   seg_o = ovr_en_i ? ovr_seg_i : SEG_DATA;
    endcase
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int BASE_W = 24,
  parameter int OFF_W  = 16,
  parameter int PL_W   = 2
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic [OFF_W-1:0]  limit_i,
  input  logic [PL_W-1:0]   dpl_i,
  input  logic [PL_W-1:0]   cpl_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [BASE_W-1:0] addr_o,
  output logic [1:0]        fault_o
);
  logic over_lim, no_priv;
  assign over_lim = off_i > limit_i;
  assign no_priv  = cpl_i > dpl_i;

  always_comb begin
    if (over_lim)     fault_o = FLT_LIMIT;
    else if (no_priv) fault_o = FLT_PRIV;
    else              fault_o = FLT_NONE;
  end

  // sum wraps at BASE_W bits
  assign addr_o = (fault_o != FLT_NONE) ? '0 : base_i + BASE_W'(off_i);
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16,
  parameter int PL_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [1:0]        ld_seg_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  input  logic [ADDR_W-1:0] ld_base_i,
  input  logic [OFF_W-1:0]  ld_limit_i,
  input  logic [PL_W-1:0]   ld_dpl_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_type_i,
  input  logic              req_ovr_en_i,
  input  logic [1:0]        req_ovr_seg_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [1:0]        vis_seg_i,
  output logic [SEL_W-1:0]  vis_sel_o,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [1:0]        rsp_fault_o
);
  logic [SEG_W-1:0]  cur_seg;
  logic [ADDR_W-1:0] cur_base;
  logic [OFF_W-1:0]  cur_limit;
  logic [PL_W-1:0]   cur_dpl;
  logic [PL_W-1:0]   cur_cpl;
  logic [ADDR_W-1:0] addr_c;
  logic [1:0]        fault_c;

  seg_pick u_pick (
    .acc_type_i (req_type_i),
    .ovr_en_i   (req_ovr_en_i),
    .ovr_seg_i  (req_ovr_seg_i),
    .seg_o      (cur_seg)
  );

  seg_reg_bank #(
    .NUM_SEG  (NUM_SEG),
    .SEL_W    (SEL_W),
    .BASE_W   (ADDR_W),
    .LIM_W    (OFF_W),
    .PL_W     (PL_W),
    .CODE_IDX (int'(SEG_CODE))
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_valid_i (ld_valid_i),
    .ld_seg_i   (ld_seg_i),
    .ld_sel_i   (ld_sel_i),
    .ld_base_i  (ld_base_i),
    .ld_limit_i (ld_limit_i),
    .ld_dpl_i   (ld_dpl_i),
    .rd_seg_i   (cur_seg),
    .rd_base_o  (cur_base),
    .rd_limit_o (cur_limit),
    .rd_dpl_o   (cur_dpl),
    .cpl_o      (cur_cpl),
    .vis_seg_i  (vis_seg_i),
    .vis_sel_o  (vis_sel_o)
  );

  seg_check #(
    .BASE_W (ADDR_W),
    .OFF_W  (OFF_W),
    .PL_W   (PL_W)
  ) u_check (
    .base_i  (cur_base),
    .limit_i (cur_limit),
    .dpl_i   (cur_dpl),
    .cpl_i   (cur_cpl),
    .off_i   (req_off_i),
    .addr_o  (addr_c),
    .fault_o (fault_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_addr_o  <= '0;
      rsp_fault_o <= FLT_NONE;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_addr_o  <= req_valid_i ? addr_c  : '0;
      rsp_fault_o <= req_valid_i ? fault_c : FLT_NONE;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16,
  parameter int PL_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [OFF_W-1:0]  req_off_i,
  input logic [OFF_W-1:0]  cur_limit,
  input logic [PL_W-1:0]   cur_dpl,
  input logic [PL_W-1:0]   cur_cpl,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] rsp_addr_o,
  input logic [1:0]        rsp_fault_o
);
  assert_rsp_follows_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_idle_no_rsp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_limit_fault_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_off_i > cur_limit) |=> rsp_fault_o == 2'b01);
  assert_priv_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_off_i <= cur_limit && cur_cpl > cur_dpl) |=> rsp_fault_o == 2'b10);
  assert_legal_ok_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_off_i <= cur_limit && cur_cpl <= cur_dpl) |=> rsp_fault_o == 2'b00);
  assert_fault_zero_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 2'b00) |-> rsp_addr_o == '0);
  assert_no_code3_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o != 2'b11);
  assert_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_addr_o == '0 && rsp_fault_o == 2'b00));
endmodule

bind seg_xlate_unit seg_xlate_chk #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .PL_W   (PL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_off_i   (req_off_i),
  .cur_limit   (cur_limit),
  .cur_dpl     (cur_dpl),
  .cur_cpl     (cur_cpl),
  .rsp_valid_o (rsp_valid_o),
  .rsp_addr_o  (rsp_addr_o),
  .rsp_fault_o (rsp_fault_o)
);

// File: tb/seg_xlate_unit_tb.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic [23:0] ld_base = '0;
  logic [15:0] ld_limit = '0;
  logic [1:0]  ld_dpl = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_type = '0;
  logic        req_ovr_en = 1'b0;
  logic [1:0]  req_ovr_seg = '0;
  logic [15:0] req_off = '0;
  logic [1:0]  vis_seg = '0;
  logic [15:0] vis_sel;
  logic        rsp_valid;
  logic [23:0] rsp_addr;
  logic [1:0]  rsp_fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_xlate_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_valid), .ld_seg_i(ld_seg), .ld_sel_i(ld_sel),
    .ld_base_i(ld_base), .ld_limit_i(ld_limit), .ld_dpl_i(ld_dpl),
    .req_valid_i(req_valid), .req_type_i(req_type), .req_ovr_en_i(req_ovr_en),
    .req_ovr_seg_i(req_ovr_seg), .req_off_i(req_off),
    .vis_seg_i(vis_seg), .vis_sel_o(vis_sel),
    .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr), .rsp_fault_o(rsp_fault)
  );

  typedef struct packed {
    logic        ldv;
    logic [1:0]  lseg;
    logic [15:0] lsel;
    logic [23:0] lbase;
    logic [15:0] llim;
    logic [1:0]  ldpl;
    logic        rqv;
    logic [1:0]  typ;
    logic        oe;
    logic [1:0]  os;
    logic [15:0] off;
    logic        ev;
    logic [23:0] ea;
    logic [1:0]  ef;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd0,1'b0,2'd0,16'h1234, 1'b1,24'h001234,2'd0, 8'd3}, // R1 reset descriptors
    '{1'b1,2'd1,16'h0010,24'h100000,16'h0FFF,2'd3, 1'b0,2'd0,1'b0,2'd0,16'h0000, 1'b0,24'h000000,2'd0, 8'd2}, // R2 load data
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd1,1'b0,2'd0,16'h0FFF, 1'b1,24'h100FFF,2'd0, 8'd4}, // R4 at limit
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd1,1'b0,2'd0,16'h1000, 1'b1,24'h000000,2'd1, 8'd4}, // R4 past limit
    '{1'b1,2'd2,16'h0018,24'hFFFF00,16'hFFFF,2'd0, 1'b1,2'd2,1'b0,2'd0,16'h0200, 1'b1,24'h000100,2'd0, 8'd9}, // R9 fwd + wrap
    '{1'b1,2'd3,16'h0020,24'h020000,16'h00FF,2'd2, 1'b0,2'd0,1'b0,2'd0,16'h0000, 1'b0,24'h000000,2'd0, 8'd2}, // R2 load extra
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd1,1'b1,2'd3,16'h0080, 1'b1,24'h020080,2'd0, 8'd8}, // R8 override
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd0,1'b1,2'd3,16'h0080, 1'b1,24'h000080,2'd0, 8'd8}, // R8 ignored on fetch
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd2,1'b1,2'd3,16'h0300, 1'b1,24'h000200,2'd0, 8'd8}, // R8 ignored on stack
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd3,1'b0,2'd0,16'h0005, 1'b1,24'h100005,2'd0, 8'd7}, // R7 type 3 -> data
    '{1'b1,2'd0,16'h0028,24'h300000,16'hFFFF,2'd3, 1'b1,2'd0,1'b0,2'd0,16'h0010, 1'b1,24'h300010,2'd0, 8'd9}, // R9 code fwd
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd2,1'b0,2'd0,16'h0010, 1'b1,24'h000000,2'd2, 8'd5}, // R5 cpl3 vs dpl0
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd1,1'b1,2'd3,16'h0010, 1'b1,24'h000000,2'd2, 8'd5}, // R5 cpl3 vs dpl2
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd1,1'b1,2'd3,16'h0100, 1'b1,24'h000000,2'd1, 8'd6}, // R6 both fail
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd1,1'b0,2'd0,16'h0020, 1'b1,24'h100020,2'd0, 8'd5}, // R5 dpl3 ok
    '{1'b1,2'd0,16'h0030,24'h300000,16'hFFFF,2'd2, 1'b1,2'd1,1'b1,2'd3,16'h0010, 1'b1,24'h020010,2'd0, 8'd9}, // R9 cpl fwd
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd2,1'b0,2'd0,16'h0000, 1'b1,24'h000000,2'd2, 8'd5}, // R5 cpl2 vs dpl0
    '{1'b1,2'd0,16'h0008,24'h000000,16'h7FFF,2'd0, 1'b0,2'd0,1'b0,2'd0,16'h0000, 1'b0,24'h000000,2'd0, 8'd3}, // R3 idle
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd2,1'b0,2'd0,16'h0000, 1'b1,24'hFFFF00,2'd0, 8'd5}, // R5 cpl0 ok
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd0,1'b0,2'd0,16'h8000, 1'b1,24'h000000,2'd1, 8'd10}, // R10 fault addr 0
    '{1'b0,2'd0,16'h0000,24'h000000,16'h0000,2'd0, 1'b1,2'd0,1'b0,2'd0,16'h7FFF, 1'b1,24'h007FFF,2'd0, 8'd4}  // R4 code limit
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ld_valid = 1'b0; req_valid = 1'b0; req_ovr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    for (int s = 0; s < 4; s++) begin
      vis_seg = 2'(s);
      #0.1;
      chk("R1 selector", 64'(vis_sel), 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      ld_valid = VEC[i].ldv; ld_seg = VEC[i].lseg; ld_sel = VEC[i].lsel;
      ld_base = VEC[i].lbase; ld_limit = VEC[i].llim; ld_dpl = VEC[i].ldpl;
      req_valid = VEC[i].rqv; req_type = VEC[i].typ; req_ovr_en = VEC[i].oe;
      req_ovr_seg = VEC[i].os; req_off = VEC[i].off;
      @(negedge clk);
      chk($sformatf("R%0d vec %0d", VEC[i].rq, i),
          {37'd0, rsp_valid, rsp_addr, rsp_fault},
          {37'd0, VEC[i].ev, VEC[i].ea, VEC[i].ef});
    end
    idle_inputs();

    // R2: selectors retained per register
    vis_seg = 2'd0; #0.1; chk("R2 code sel",  64'(vis_sel), 64'h0008);
    vis_seg = 2'd1; #0.1; chk("R2 data sel",  64'(vis_sel), 64'h0010);
    vis_seg = 2'd2; #0.1; chk("R2 stack sel", 64'(vis_sel), 64'h0018);
    vis_seg = 2'd3; #0.1; chk("R2 extra sel", 64'(vis_sel), 64'h0020);

    // R1: reset mid-run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", 64'(rsp_valid), 64'd0);
    vis_seg = 2'd1; #0.1; chk("R1 data sel cleared", 64'(vis_sel), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'd2; req_off = 16'hFFFF;
    @(negedge clk);
    chk("R1 stack default", {38'd0, rsp_addr, rsp_fault}, {38'd0, 24'h00FFFF, 2'd0});
    idle_inputs();
    @(negedge clk);
    finish_run();
  end
endmodule